// File: doc/BRIEF.md
# Frame-Linear Display Timing Engine

This block produces the raster timing for one display output. Software programs a small register set through a plain write port. The set holds the line length, the hsync pulse width, the frame length, the vsync pulse length, the active window, the border and underflow colours and the sync polarities. The engine then drives hsync, vsync, data-enable and a pixel-request strobe. It also gives a one-clock pulse at the start of each frame and at the start of each line.

Vertical timing has no line counter. One counter runs across the whole frame in pixel clocks, and the frame length, the vsync length and the vertical window bounds are all absolute positions on that count. A second counter gives the position inside the line, and the active window is decoded from both counters.

Timing registers are shadow copies. They move into the working set only when a frame starts, and a change to the enable bit also takes effect only on a frame boundary. In follower mode the engine ignores its own enable bit and starts and stops on a level input. Two engines with the same timing can then run in lockstep for a split panel: the follower's input is tied to the leader's `sync_en_o`.

Top module: `disp_timing_engine`

## Requirements
- R1: After reset all outputs are low: hsync, vsync, data-enable, pixel request, both pulses and the colour output.
- R2: While running, the position in the line counts 0 to (line length − 1), with the line length taken from bits [15:0] of register 0. Hsync is active for positions below the pulse width in bits [31:16] of register 0. line_start_o is high only at position 0.
- R3: While running, the frame position counts 0 to (frame length − 1) in pixel clocks, with the frame length taken from register 1. Vsync is active for frame positions below the value of register 2.
- R4: de_o and pix_req_o are high only when the line position lies in [bits 15:0, bits 31:16] of register 3 and the frame position lies in [register 4, register 5], both bounds inclusive.
- R5: When data-enable is high, rgb_o carries pix_data_i if pix_valid_i is high and the underflow colour (register 7) if it is low. When data-enable is low, rgb_o carries the border colour (register 6).
- R6: Register 8 bit 0 makes hsync active-low and bit 1 makes vsync active-low. While idle, each sync output rests at its inactive level.
- R7: Register 9 bit 0 is the enable. Clearing it mid-frame lets the current frame finish, and the engine goes idle after the last position. Setting it again before that last position keeps the engine running with no gap.
- R8: From idle, the frame starts (frame_start_o high, both positions 0) in the cycle after the second rising edge following the enabling write.
- R9: A timing or colour write made mid-frame leaves the current frame unchanged and applies from the next frame start.
- R10: With register 10 bit 0 set, the engine starts and stops from master_en_i (start on the first edge that sees it high, stop at a frame end) and ignores its own enable bit. sync_en_o always shows the stored enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write data |
| master_en_i | input | 1 | Run request from a leader engine, used in follower mode |
| pix_valid_i | input | 1 | Upstream pixel present this cycle |
| pix_data_i | input | CW | Upstream pixel colour |
| pix_req_o | output | 1 | Pixel request, high inside the active window |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| rgb_o | output | CW | Output colour |
| frame_start_o | output | 1 | One-clock pulse at frame position 0 |
| line_start_o | output | 1 | One-clock pulse at line position 0 |
| sync_en_o | output | 1 | Stored enable bit, for driving a follower |

## Verification
A wrong frame or line position shows as a sync edge or a data-enable edge in the wrong cycle. That error is visible within one line, and for vertical faults within one frame. The bench therefore compares every output in every cycle against a position computed from the start cycle. A fault in the enable or shadow logic appears at the next frame boundary: the engine stops early or late, leaves a gap, or shows a new colour one frame too soon. Each run therefore crosses at least one boundary with a write pending.

// File: rtl/disp_tg_pkg.sv
`timescale 1ns/1ps
// Shared register indices and field positions for the display timing engine.
package disp_tg_pkg;
    typedef enum logic [3:0] {
        RA_HTIME  = 4'd0,   // [15:0] line length, [31:16] hsync width
        RA_FLEN   = 4'd1,   // frame length in pixel clocks
        RA_VSLEN  = 4'd2,   // vsync length in pixel clocks
        RA_HWIN   = 4'd3,   // [15:0] first active pixel, [31:16] last
        RA_VFIRST = 4'd4,   // first active frame position
        RA_VLAST  = 4'd5,   // last active frame position
        RA_BORDER = 4'd6,
        RA_UFLOW  = 4'd7,
        RA_POLAR  = 4'd8,
        RA_ENABLE = 4'd9,
        RA_FOLLOW = 4'd10
    } reg_addr_e;

    localparam int POL_H_BIT = 0;
    localparam int POL_V_BIT = 1;
    localparam int HI_FIELD  = 16;
endpackage

// File: rtl/disp_tg_regs.sv
`timescale 1ns/1ps
// Register file of the timing engine: shadow copies written from the
// write port, and a working set copied from them when load is high.
// Assumes HW <= 16 and FW, CW <= 32.
module disp_tg_regs #(
    parameter int HW = 16,
    parameter int FW = 24,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          load,
    output logic [HW-1:0] act_hper,
    output logic [HW-1:0] act_hpw,
    output logic [HW-1:0] act_hfirst,
    output logic [HW-1:0] act_hlast,
    output logic [FW-1:0] act_vper,
    output logic [FW-1:0] act_vlen,
    output logic [FW-1:0] act_vfirst,
    output logic [FW-1:0] act_vlast,
    output logic [CW-1:0] act_border,
    output logic [CW-1:0] act_uflow,
    output logic          act_hpol,
    output logic          act_vpol,
    output logic          en_req_o,
    output logic          follow_o
);
    import disp_tg_pkg::*;

    logic [HW-1:0] sh_hper, sh_hpw, sh_hfirst, sh_hlast;
    logic [FW-1:0] sh_vper, sh_vlen, sh_vfirst, sh_vlast;
    logic [CW-1:0] sh_border, sh_uflow;
    logic          sh_hpol, sh_vpol;

    // Decode the write port into the shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hper   <= '0;
            sh_hpw    <= '0;
            sh_hfirst <= '0;
            sh_hlast  <= '0;
            sh_vper   <= '0;
            sh_vlen   <= '0;
            sh_vfirst <= '0;
            sh_vlast  <= '0;
            sh_border <= '0;
            sh_uflow  <= '0;
            sh_hpol   <= 1'b0;
            sh_vpol   <= 1'b0;
            en_req_o  <= 1'b0;
            follow_o  <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_HTIME: begin
                    sh_hper <= wr_data[HW-1:0];
                    sh_hpw  <= wr_data[HI_FIELD +: HW];
                end
                RA_FLEN:   sh_vper   <= wr_data[FW-1:0];
                RA_VSLEN:  sh_vlen   <= wr_data[FW-1:0];
                RA_HWIN: begin
                    sh_hfirst <= wr_data[HW-1:0];
                    sh_hlast  <= wr_data[HI_FIELD +: HW];
                end
                RA_VFIRST: sh_vfirst <= wr_data[FW-1:0];
                RA_VLAST:  sh_vlast  <= wr_data[FW-1:0];
                RA_BORDER: sh_border <= wr_data[CW-1:0];
                RA_UFLOW:  sh_uflow  <= wr_data[CW-1:0];
                RA_POLAR: begin
                    sh_hpol <= wr_data[POL_H_BIT];
                    sh_vpol <= wr_data[POL_V_BIT];
                end
                RA_ENABLE: en_req_o <= wr_data[0];
                RA_FOLLOW: follow_o <= wr_data[0];
                default: ;
            endcase
        end
    end

    // Copy the shadow set into the working set at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hper   <= '0;
            act_hpw    <= '0;
            act_hfirst <= '0;
            act_hlast  <= '0;
            act_vper   <= '0;
            act_vlen   <= '0;
            act_vfirst <= '0;
            act_vlast  <= '0;
            act_border <= '0;
            act_uflow  <= '0;
            act_hpol   <= 1'b0;
            act_vpol   <= 1'b0;
        end else if (load) begin
            act_hper   <= sh_hper;
            act_hpw    <= sh_hpw;
            act_hfirst <= sh_hfirst;
            act_hlast  <= sh_hlast;
            act_vper   <= sh_vper;
            act_vlen   <= sh_vlen;
            act_vfirst <= sh_vfirst;
            act_vlast  <= sh_vlast;
            act_border <= sh_border;
            act_uflow  <= sh_uflow;
            act_hpol   <= sh_hpol;
            act_vpol   <= sh_vpol;
        end
    end

    // R9: the working set changes only on a load from the sequencer.
    a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_hper) && $stable(act_vper) && $stable(act_border)
                   && $stable(act_hpol) && $stable(act_vpol)));
endmodule

// File: rtl/disp_tg_seq.sv
`timescale 1ns/1ps
// Sequencer: the run flag, the line position counter and the frame-linear
// position counter. Enable changes (go) are sampled only while idle or on
// the last position of a frame. Assumes the frame length is a multiple of
// the line length.
module disp_tg_seq #(
    parameter int HW = 16,
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [HW-1:0] hper,
    input  logic [FW-1:0] vper,
    output logic          running_o,
    output logic [HW-1:0] h_pos_o,
    output logic [FW-1:0] f_pos_o,
    output logic          load_o
);
    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [FW-1:0] F_ONE = FW'(1);

    logic line_end, frame_end, boundary;

    // Detect the end of a line, the end of a frame and the frame boundary.
    always_comb begin
        line_end  = (h_pos_o == hper - H_ONE);
        frame_end = (f_pos_o == vper - F_ONE);
        boundary  = !running_o || frame_end;
        load_o    = boundary && go;
    end

    // Advance both position counters and apply go at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            h_pos_o   <= '0;
            f_pos_o   <= '0;
        end else if (boundary) begin
            running_o <= go;
            h_pos_o   <= '0;
            f_pos_o   <= '0;
        end else begin
            f_pos_o <= f_pos_o + F_ONE;
            h_pos_o <= line_end ? '0 : h_pos_o + H_ONE;
        end
    end

    // R7: the engine only leaves the running state after a frame's last position.
    a_r7_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> $past(f_pos_o + F_ONE == vper));
    // R8: a started frame begins at position zero on both counters.
    a_r8_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running_o) |-> (f_pos_o == '0 && h_pos_o == '0));
    // R2: the line position stays below the line length.
    a_r2_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && hper != '0) |-> (h_pos_o < hper));
    // R3: the frame position stays below the frame length.
    a_r3_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && vper != '0) |-> (f_pos_o < vper));
endmodule

// File: rtl/disp_tg_out.sv
`timescale 1ns/1ps
// Output decode: sync pulses with polarity, the active window and the colour
// choice between pixel, underflow and border. Purely combinational from the
// sequencer state and the working register set.
module disp_tg_out #(
    parameter int HW = 16,
    parameter int FW = 24,
    parameter int CW = 24
) (
    input  logic          running,
    input  logic [HW-1:0] h_pos,
    input  logic [FW-1:0] f_pos,
    input  logic [HW-1:0] hpw,
    input  logic [HW-1:0] hfirst,
    input  logic [HW-1:0] hlast,
    input  logic [FW-1:0] vlen,
    input  logic [FW-1:0] vfirst,
    input  logic [FW-1:0] vlast,
    input  logic [CW-1:0] border,
    input  logic [CW-1:0] uflow,
    input  logic          hpol,
    input  logic          vpol,
    input  logic          pix_valid,
    input  logic [CW-1:0] pix_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_req,
    output logic [CW-1:0] rgb,
    output logic          frame_start,
    output logic          line_start
);
    logic in_h, in_v;

    // Decode the window and the syncs from the two positions.
    always_comb begin
        in_h        = (h_pos >= hfirst) && (h_pos <= hlast);
        in_v        = (f_pos >= vfirst) && (f_pos <= vlast);
        de          = running && in_h && in_v;
        pix_req     = de;
        hsync       = (running && (h_pos < hpw)) ^ hpol;
        vsync       = (running && (f_pos < vlen)) ^ vpol;
        frame_start = running && (f_pos == '0);
        line_start  = running && (h_pos == '0);
    end

    // Choose the output colour.
    always_comb begin
        if (!de)            rgb = border;
        else if (pix_valid) rgb = pix_data;
        else                rgb = uflow;
    end
endmodule

// File: rtl/disp_timing_engine.sv
`timescale 1ns/1ps
// Display timing engine top: register file, sequencer and output decode.
// In follower mode the run request comes from master_en_i instead of the
// stored enable bit; sync_en_o exports that bit for a follower engine.
module disp_timing_engine #(
    parameter int HW = 16,
    parameter int FW = 24,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          master_en_i,
    input  logic          pix_valid_i,
    input  logic [CW-1:0] pix_data_i,
    output logic          pix_req_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] rgb_o,
    output logic          frame_start_o,
    output logic          line_start_o,
    output logic          sync_en_o
);
    logic [HW-1:0] act_hper, act_hpw, act_hfirst, act_hlast;
    logic [FW-1:0] act_vper, act_vlen, act_vfirst, act_vlast;
    logic [CW-1:0] act_border, act_uflow;
    logic          act_hpol, act_vpol, en_req, follow, go, load, running;
    logic [HW-1:0] h_pos;
    logic [FW-1:0] f_pos;

    // Pick the run request source.
    always_comb begin
        go        = follow ? master_en_i : en_req;
        sync_en_o = en_req;
    end

    disp_tg_regs #(.HW(HW), .FW(FW), .CW(CW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load),
        .act_hper(act_hper), .act_hpw(act_hpw), .act_hfirst(act_hfirst),
        .act_hlast(act_hlast), .act_vper(act_vper), .act_vlen(act_vlen),
        .act_vfirst(act_vfirst), .act_vlast(act_vlast),
        .act_border(act_border), .act_uflow(act_uflow),
        .act_hpol(act_hpol), .act_vpol(act_vpol),
        .en_req_o(en_req), .follow_o(follow)
    );

    disp_tg_seq #(.HW(HW), .FW(FW)) seq_i (
        .clk(clk), .rst_n(rst_n), .go(go), .hper(act_hper), .vper(act_vper),
        .running_o(running), .h_pos_o(h_pos), .f_pos_o(f_pos), .load_o(load)
    );

    disp_tg_out #(.HW(HW), .FW(FW), .CW(CW)) out_i (
        .running(running), .h_pos(h_pos), .f_pos(f_pos),
        .hpw(act_hpw), .hfirst(act_hfirst), .hlast(act_hlast),
        .vlen(act_vlen), .vfirst(act_vfirst), .vlast(act_vlast),
        .border(act_border), .uflow(act_uflow),
        .hpol(act_hpol), .vpol(act_vpol),
        .pix_valid(pix_valid_i), .pix_data(pix_data_i),
        .hsync(hsync_o), .vsync(vsync_o), .de(de_o), .pix_req(pix_req_o),
        .rgb(rgb_o), .frame_start(frame_start_o), .line_start(line_start_o)
    );

    // R3: every frame start is also a line start.
    a_r3_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> line_start_o);
    // R6: an idle engine holds both syncs at their inactive level, no window.
    a_r6_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (hsync_o == act_hpol && vsync_o == act_vpol && !de_o && !pix_req_o));
    // R10: a start needs the selected run request in the previous cycle.
    a_r10_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(follow ? master_en_i : en_req));
    // R5: the colour is the border whenever data-enable is low.
    a_r5_border_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !de_o |-> (rgb_o == act_border));
endmodule

// File: tb/disp_timing_engine_tb.sv
`timescale 1ns/1ps
module disp_timing_engine_tb_top;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          master_en_i = 1'b0;
    logic          pix_valid_i = 1'b0;
    logic [CW-1:0] pix_data_i = '0;
    logic          pix_req_o, hsync_o, vsync_o, de_o, frame_start_o, line_start_o, sync_en_o;
    logic [CW-1:0] rgb_o;

    disp_timing_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .master_en_i(master_en_i),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
        .pix_req_o(pix_req_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .rgb_o(rgb_o), .frame_start_o(frame_start_o),
        .line_start_o(line_start_o), .sync_en_o(sync_en_o)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // current programmed configuration
    int unsigned c_hper, c_hpw, c_vper, c_vlen, c_hs, c_he, c_vs, c_ve;
    logic        c_hp, c_vp;
    logic [CW-1:0] c_border, c_uflow, b_new;
    // per-run events
    int ev1_k, ev2_k, m_k, bsw_k;
    logic [3:0]  ev1_a, ev2_a;
    logic [31:0] ev1_d, ev2_d;
    logic        m_val;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_cfg();
        wr(4'd0, {c_hpw[15:0], c_hper[15:0]});
        wr(4'd1, c_vper);
        wr(4'd2, c_vlen);
        wr(4'd3, {c_he[15:0], c_hs[15:0]});
        wr(4'd4, c_vs);
        wr(4'd5, c_ve);
        wr(4'd6, 32'(c_border));
        wr(4'd7, 32'(c_uflow));
        wr(4'd8, {30'd0, c_vp, c_hp});
    endtask

    task automatic clear_ev();
        ev1_k = -1; ev2_k = -1; m_k = -1; bsw_k = 32'h4000_0000; m_val = 1'b0;
    endtask

    task automatic check_cycle(input int k, input bit run);
        logic [CW-1:0] bord, erg;
        logic eh, ev, ede, efs, els;
        int unsigned h, f;
        bord = (k >= bsw_k) ? b_new : c_border;
        h = k % c_hper;
        f = k % c_vper;
        if (run) begin
            eh  = (h < c_hpw) ^ c_hp;
            ev  = (f < c_vlen) ^ c_vp;
            ede = (h >= c_hs) && (h <= c_he) && (f >= c_vs) && (f <= c_ve);
            erg = ede ? (pix_valid_i ? pix_data_i : c_uflow) : bord;
            efs = (f == 0);
            els = (h == 0);
            chk(c_hp ? "R6" : "R2", "hsync", 32'(hsync_o), 32'(eh));
            chk(c_vp ? "R6" : "R3", "vsync", 32'(vsync_o), 32'(ev));
            chk("R2", "line_start", 32'(line_start_o), 32'(els));
            chk("R8", "frame_start", 32'(frame_start_o), 32'(efs));
            chk("R4", "de", 32'(de_o), 32'(ede));
            chk("R4", "pix_req", 32'(pix_req_o), 32'(ede));
            chk((k >= bsw_k) ? "R9" : "R5", "rgb", 32'(rgb_o), 32'(erg));
        end else begin
            chk("R7", "idle hsync", 32'(hsync_o), 32'(c_hp));
            chk("R7", "idle vsync", 32'(vsync_o), 32'(c_vp));
            chk("R7", "idle de", 32'(de_o), 32'd0);
            chk("R7", "idle pulses", {30'd0, frame_start_o, line_start_o}, 32'd0);
            chk("R7", "idle rgb", 32'(rgb_o), 32'(bord));
        end
    endtask

    // Runs from frame position 0 (current time: negedge after the start edge).
    task automatic run_seq(input int total, input int stop_k);
        for (int k = 0; k < total; k++) begin
            wr_en = 1'b0;
            if (k == ev1_k) begin wr_en = 1'b1; wr_addr = ev1_a; wr_data = ev1_d; end
            if (k == ev2_k) begin wr_en = 1'b1; wr_addr = ev2_a; wr_data = ev2_d; end
            if (k == m_k) master_en_i = m_val;
            pix_valid_i = ($urandom % 4) != 0;
            pix_data_i  = CW'($urandom);
            #1;
            check_cycle(k, k < stop_k);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic start_en();
        wr(4'd9, 32'd1);
        @(negedge clk);
    endtask

    task automatic quiesce();
        wr(4'd9, 32'd0);
        wr(4'd10, 32'd0);
        master_en_i = 1'b0;
        repeat (200) @(negedge clk);
    endtask

    task automatic rand_cfg();
        int unsigned lines;
        c_hper = 6 + $urandom % 15;
        c_hpw  = 1 + $urandom % (c_hper - 1);
        lines  = 3 + $urandom % 6;
        c_vper = c_hper * lines;
        c_vlen = c_hper * (1 + $urandom % (lines - 1));
        c_hs   = $urandom % c_hper;
        c_he   = c_hs + $urandom % (c_hper - c_hs);
        c_vs   = $urandom % c_vper;
        c_ve   = c_vs + $urandom % (c_vper - c_vs);
        c_hp   = $urandom % 2;
        c_vp   = $urandom % 2;
        c_border = CW'($urandom);
        c_uflow  = CW'($urandom);
    endtask

    // Enable, run two frames, clear enable mid second frame, watch it stop.
    task automatic two_frame_run();
        int kw;
        clear_ev();
        program_cfg();
        start_en();
        kw = c_vper + ($urandom % (c_vper - 1));
        ev1_k = kw; ev1_a = 4'd9; ev1_d = 32'd0;
        run_seq(2 * c_vper + 6, 2 * c_vper);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        c_hp = 1'b0; c_vp = 1'b0; c_border = '0; c_uflow = '0;
        c_hper = 8; c_vper = 32;
        clear_ev();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "reset syncs", {30'd0, hsync_o, vsync_o}, 32'd0);
        chk("R1", "reset de/req", {30'd0, de_o, pix_req_o}, 32'd0);
        chk("R1", "reset pulses", {30'd0, frame_start_o, line_start_o}, 32'd0);
        chk("R1", "reset rgb", 32'(rgb_o), 32'd0);
        @(negedge clk);

        // Directed: full-line window, both polarities low, wide hsync (R6, R4)
        c_hper = 10; c_hpw = 9; c_vper = 40; c_vlen = 10;
        c_hs = 0; c_he = 9; c_vs = 0; c_ve = 39; c_hp = 1; c_vp = 1;
        c_border = 24'h123456; c_uflow = 24'h0000ff;
        two_frame_run();
        quiesce();

        // Directed: single-pixel window (R4)
        c_hper = 7; c_hpw = 1; c_vper = 28; c_vlen = 7;
        c_hs = 3; c_he = 3; c_vs = 10; c_ve = 10; c_hp = 0; c_vp = 0;
        c_border = 24'habcdef; c_uflow = 24'hff0000;
        two_frame_run();
        quiesce();

        // R7: disable then re-enable within the same frame: no gap
        clear_ev();
        program_cfg();
        start_en();
        ev1_k = 5; ev1_a = 4'd9; ev1_d = 32'd0;
        ev2_k = c_vper - 3; ev2_a = 4'd9; ev2_d = 32'd1;
        run_seq(3 * c_vper, 32'h4000_0000);
        quiesce();

        // R9: mid-frame border write applies from the next frame
        clear_ev();
        program_cfg();
        start_en();
        b_new = 24'h5a5a5a;
        ev1_k = 3; ev1_a = 4'd6; ev1_d = 32'(b_new);
        bsw_k = c_vper;
        ev2_k = c_vper + 4; ev2_a = 4'd9; ev2_d = 32'd0;
        run_seq(2 * c_vper + 6, 2 * c_vper);
        c_border = b_new;
        quiesce();

        // Random configurations (R2..R8)
        for (int i = 0; i < 8; i++) begin
            rand_cfg();
            two_frame_run();
            quiesce();
        end

        // R10: follower mode ignores the own enable bit and follows master_en_i
        clear_ev();
        wr(4'd10, 32'd1);
        wr(4'd9, 32'd1);
        #1;
        chk("R10", "sync_en_o", 32'(sync_en_o), 32'd1);
        @(negedge clk);
        repeat (6) begin
            #1;
            chk("R10", "follower idle hsync", 32'(hsync_o), 32'(c_hp));
            chk("R10", "follower idle pulse", 32'(frame_start_o), 32'd0);
            @(negedge clk);
        end
        master_en_i = 1'b1;
        @(negedge clk);
        m_k = c_vper + 2; m_val = 1'b0;
        run_seq(2 * c_vper + 6, 2 * c_vper);
        #1;
        chk("R10", "sync_en_o kept", 32'(sync_en_o), 32'd1);
        quiesce();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule